// File: doc/BRIEF.md
# TDM Sample Bus Slot Sequencer

This block paces a shared synchronous sample bus that links a router agent with several DSP agents. A frame opens on a frame-start pulse. It is split into 64 numbered slots, and every slot is split into 4 bus cycles. An enable tick consumes one bus cycle. The sequencer tracks the slot and cycle counters and decides which agent owns the current position. It then places that agent's 24-bit word on a single broadcast bus, together with a one-cycle strobe for each valid word.

Slots 0 through 7 belong to the router, which uses them for audio out, audio in and mix-send traffic. Each DSP agent has one slot, fixed by a parameter, in the range 8 to 63. In that slot it may present up to four words, one per bus cycle. Every agent listens to the same broadcast bus, so a word written early in a frame can be consumed by another agent later in the same frame. If two DSP agents are given the same slot, the lower-indexed one keeps it and a sticky flag records the clash.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: After reset the outputs are as follows: slot 0, cycle 0, grant_o all zero, bus_data_o zero, bus_strobe_o low, frame_end_o low and conflict_o low. Until the first frame_start_i no agent is granted and ticks do not move the counters.
- R2: A frame_start_i sampled at a clock edge sets the position to slot 0, cycle 0 and opens the frame. It takes priority over a tick in the same cycle.
- R3: While the frame is open, each clock with tick_i high advances cycle_o by one. After cycle 3, cycle_o wraps to 0 and slot_o increments. With tick_i low, the position holds.
- R4: A tick at slot 63, cycle 3 raises frame_end_o in that same cycle and closes the frame. The position then stays at 63/3, and later ticks neither pulse frame_end_o nor grant anyone until the next frame_start_i.
- R5: In slots 0 to 7 of an open frame, only the router is granted (grant_o bit N_AGENTS). The bus carries rtr_data_i while rtr_valid_i is high, and DSP inputs are ignored.
- R6: In an open frame, at the slot assigned to DSP agent i (8 or higher), grant_o bit i is set. The bus carries that agent's 24-bit word, taken from bits [i*24 +: 24] of dsp_data_i, in each cycle where dsp_valid_i bit i is high. That allows up to 4 words per slot. Words from other agents are ignored.
- R7: bus_data_o is zero and bus_strobe_o is low in any of these cases: the granted agent's valid is low, no agent owns the current slot, or the frame is closed.
- R8: bus_strobe_o is high only in a cycle where tick_i is high and a granted agent presents a valid word. That gives exactly one strobe per transferred word.
- R9: When two DSP agents share a slot, only the lower-indexed agent is granted and drives. conflict_o rises on the clock edge after that slot becomes current in an open frame, and stays high until reset, including across later frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Opens a frame at slot 0, cycle 0 |
| tick_i | input | 1 | Consumes the current bus cycle |
| rtr_valid_i | input | 1 | Router word valid |
| rtr_data_i | input | 24 | Router word |
| dsp_valid_i | input | N_AGENTS | Per-DSP word valid |
| dsp_data_i | input | N_AGENTS*24 | Per-DSP words, agent i at [i*24 +: 24] |
| bus_data_o | output | 24 | Broadcast bus word seen by all agents |
| bus_strobe_o | output | 1 | One pulse per transferred word |
| grant_o | output | N_AGENTS+1 | One-hot owner; top bit is the router |
| slot_o | output | 6 | Current slot number |
| cycle_o | output | 2 | Current bus cycle within the slot |
| frame_end_o | output | 1 | Pulse on the tick that consumes the last cycle |
| conflict_o | output | 1 | Sticky flag for a shared DSP slot |

## Verification
The hardest conditions to reach are the two ends of the frame and the doubly assigned slot. Reaching the closing edge takes 255 consumed cycles, and a slot clash cannot occur at all with a valid default configuration. The bench uses a positioning task that opens a frame and issues an exact number of ticks to land on any slot and cycle. It also runs a second instance, built with two agents on the same slot, in parallel on the same stimulus. This exposes the lower-index priority and the sticky flag across a restart.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    localparam int unsigned TDM_SLOTS        = 64;
    localparam int unsigned TDM_CYCLES       = 4;
    localparam int unsigned TDM_ROUTER_SLOTS = 8;
    localparam int unsigned TDM_DATA_W       = 24;

    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,
        OWN_ROUTER = 2'd1,
        OWN_DSP    = 2'd2
    } owner_kind_e;

    function automatic logic is_last_pos(input int unsigned slot, input int unsigned cyc,
                                         input int unsigned n_slots, input int unsigned n_cyc);
        return (slot == n_slots - 1) && (cyc == n_cyc - 1);
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int unsigned N_SLOTS = 64,
    parameter int unsigned N_CYC   = 4,
    parameter int unsigned SLOT_W  = $clog2(N_SLOTS),
    parameter int unsigned CYC_W   = $clog2(N_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start_i,
    input  logic              tick_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [CYC_W-1:0]  cycle_o,
    output logic              active_o,
    output logic              frame_end_o
);
    import tdm_seq_pkg::*;

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(N_CYC - 1);

    logic at_last;
    assign at_last     = is_last_pos(int'(slot_o), int'(cycle_o), N_SLOTS, N_CYC);
    assign frame_end_o = active_o && tick_i && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_o   <= '0;
            cycle_o  <= '0;
            active_o <= 1'b0;
        end else if (frame_start_i) begin
            slot_o   <= '0;
            cycle_o  <= '0;
            active_o <= 1'b1;
        end else if (active_o && tick_i) begin
            if (at_last) begin
                active_o <= 1'b0;
            end else if (cycle_o == CYC_LAST) begin
                cycle_o <= '0;
                slot_o  <= slot_o + 1'b1;
            end else begin
                cycle_o <= cycle_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_owner_decode.sv
module tdm_owner_decode #(
    parameter int unsigned N_AGENTS  = 3,
    parameter int unsigned N_SLOTS   = 64,
    parameter int unsigned RTR_SLOTS = 8,
    parameter int unsigned SLOT_W    = $clog2(N_SLOTS),
    parameter logic [N_AGENTS*SLOT_W-1:0] AGENT_SLOTS = '0
) (
    input  logic [SLOT_W-1:0]        slot_i,
    output tdm_seq_pkg::owner_kind_e kind_o,
    output logic [N_AGENTS-1:0]      sel_o,
    output logic                     contested_o
);
    import tdm_seq_pkg::*;

    localparam logic [SLOT_W-1:0] RTR_LIM = SLOT_W'(RTR_SLOTS);

    logic                in_router;
    logic [N_AGENTS-1:0] hit;

    assign in_router = (slot_i < RTR_LIM);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        localparam logic [SLOT_W-1:0] MY_SLOT = AGENT_SLOTS[i*SLOT_W +: SLOT_W];
        assign hit[i] = !in_router && (slot_i == MY_SLOT);
        if (i == 0) begin : g_first
            assign sel_o[i] = hit[i];
        end else begin : g_rest
            assign sel_o[i] = hit[i] && !(|hit[i-1:0]);
        end
    end

    assign contested_o = ($countones(hit) > 1);

    always_comb begin
        if (in_router)   kind_o = OWN_ROUTER;
        else if (|hit)   kind_o = OWN_DSP;
        else             kind_o = OWN_NONE;
    end

endmodule

// File: rtl/tdm_bus_mux.sv
module tdm_bus_mux #(
    parameter int unsigned N_AGENTS = 3,
    parameter int unsigned DATA_W   = 24
) (
    input  logic                         active_i,
    input  logic                         tick_i,
    input  tdm_seq_pkg::owner_kind_e     kind_i,
    input  logic [N_AGENTS-1:0]          sel_i,
    input  logic                         rtr_valid_i,
    input  logic [DATA_W-1:0]            rtr_data_i,
    input  logic [N_AGENTS-1:0]          dsp_valid_i,
    input  logic [N_AGENTS*DATA_W-1:0]   dsp_data_i,
    output logic [N_AGENTS:0]            grant_o,
    output logic [DATA_W-1:0]            data_o,
    output logic                         strobe_o
);
    import tdm_seq_pkg::*;

    logic              dsp_ok;
    logic              word_ok;
    logic [DATA_W-1:0] dsp_word;
    logic [DATA_W-1:0] pick;

    always_comb begin
        dsp_word = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (sel_i[i]) dsp_word = dsp_word | dsp_data_i[i*DATA_W +: DATA_W];
        end
        dsp_ok  = |(sel_i & dsp_valid_i);
        word_ok = ((kind_i == OWN_ROUTER) && rtr_valid_i) || ((kind_i == OWN_DSP) && dsp_ok);
        pick    = (kind_i == OWN_ROUTER) ? rtr_data_i : dsp_word;

        grant_o = '0;
        if (active_i) begin
            grant_o[N_AGENTS] = (kind_i == OWN_ROUTER);
            if (kind_i == OWN_DSP) grant_o[N_AGENTS-1:0] = sel_i;
        end

        data_o   = (active_i && word_ok) ? pick : '0;
        strobe_o = active_i && word_ok && tick_i;
    end

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer #(
    parameter int unsigned N_AGENTS  = 3,
    parameter int unsigned DATA_W    = tdm_seq_pkg::TDM_DATA_W,
    parameter int unsigned N_SLOTS   = tdm_seq_pkg::TDM_SLOTS,
    parameter int unsigned N_CYC     = tdm_seq_pkg::TDM_CYCLES,
    parameter int unsigned RTR_SLOTS = tdm_seq_pkg::TDM_ROUTER_SLOTS,
    parameter int unsigned SLOT_W    = $clog2(N_SLOTS),
    parameter int unsigned CYC_W     = $clog2(N_CYC),
    parameter logic [N_AGENTS*SLOT_W-1:0] AGENT_SLOTS = {6'd63, 6'd20, 6'd8}
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_start_i,
    input  logic                       tick_i,
    input  logic                       rtr_valid_i,
    input  logic [DATA_W-1:0]          rtr_data_i,
    input  logic [N_AGENTS-1:0]        dsp_valid_i,
    input  logic [N_AGENTS*DATA_W-1:0] dsp_data_i,
    output logic [DATA_W-1:0]          bus_data_o,
    output logic                       bus_strobe_o,
    output logic [N_AGENTS:0]          grant_o,
    output logic [SLOT_W-1:0]          slot_o,
    output logic [CYC_W-1:0]           cycle_o,
    output logic                       frame_end_o,
    output logic                       conflict_o
);
    import tdm_seq_pkg::*;

    logic                active;
    logic                contested;
    owner_kind_e         kind;
    logic [N_AGENTS-1:0] sel;

    tdm_slot_counter #(
        .N_SLOTS(N_SLOTS), .N_CYC(N_CYC), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .tick_i(tick_i),
        .slot_o(slot_o), .cycle_o(cycle_o), .active_o(active), .frame_end_o(frame_end_o)
    );

    tdm_owner_decode #(
        .N_AGENTS(N_AGENTS), .N_SLOTS(N_SLOTS), .RTR_SLOTS(RTR_SLOTS),
        .SLOT_W(SLOT_W), .AGENT_SLOTS(AGENT_SLOTS)
    ) u_dec (
        .slot_i(slot_o), .kind_o(kind), .sel_o(sel), .contested_o(contested)
    );

    tdm_bus_mux #(
        .N_AGENTS(N_AGENTS), .DATA_W(DATA_W)
    ) u_mux (
        .active_i(active), .tick_i(tick_i), .kind_i(kind), .sel_i(sel),
        .rtr_valid_i(rtr_valid_i), .rtr_data_i(rtr_data_i),
        .dsp_valid_i(dsp_valid_i), .dsp_data_i(dsp_data_i),
        .grant_o(grant_o), .data_o(bus_data_o), .strobe_o(bus_strobe_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                         conflict_o <= 1'b0;
        else if (active && contested)    conflict_o <= 1'b1;
    end

endmodule

// File: rtl/tdm_seq_checker.sv
module tdm_seq_checker #(
    parameter int unsigned N_AGENTS  = 3,
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned N_SLOTS   = 64,
    parameter int unsigned N_CYC     = 4,
    parameter int unsigned RTR_SLOTS = 8,
    parameter int unsigned SLOT_W    = 6,
    parameter int unsigned CYC_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start_i,
    input logic              tick_i,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              bus_strobe_o,
    input logic [N_AGENTS:0] grant_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic [CYC_W-1:0]  cycle_o,
    input logic              frame_end_o,
    input logic              conflict_o
);

    p_start_home_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start_i |=> (slot_o == '0) && (cycle_o == '0));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !frame_start_i) |=> ($stable(slot_o) && $stable(cycle_o)));

    p_end_at_last_r4: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> (slot_o == SLOT_W'(N_SLOTS - 1)) && (cycle_o == CYC_W'(N_CYC - 1)));

    p_router_low_r5: assert property (@(posedge clk) disable iff (rst)
        grant_o[N_AGENTS] |-> (slot_o < SLOT_W'(RTR_SLOTS)));

    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0) |-> ((bus_data_o == '0) && !bus_strobe_o));

    p_strobe_tick_r8: assert property (@(posedge clk) disable iff (rst)
        bus_strobe_o |-> tick_i);

    p_conflict_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        conflict_o |=> conflict_o);

endmodule

bind tdm_slot_sequencer tdm_seq_checker #(
    .N_AGENTS(N_AGENTS), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .N_CYC(N_CYC),
    .RTR_SLOTS(RTR_SLOTS), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
) u_chk (
    .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .tick_i(tick_i),
    .bus_data_o(bus_data_o), .bus_strobe_o(bus_strobe_o), .grant_o(grant_o),
    .slot_o(slot_o), .cycle_o(cycle_o), .frame_end_o(frame_end_o),
    .conflict_o(conflict_o)
);

// File: tb/tb_tdm_slot_sequencer.sv
module tb_tdm_slot_sequencer;

    localparam int NA = 3;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_start_i;
    logic          tick_i;
    logic          rtr_valid_i;
    logic [DW-1:0] rtr_data_i;
    logic [NA-1:0] dsp_valid_i;
    logic [NA*DW-1:0] dsp_data_i;

    logic [DW-1:0] bus_data_o, c_bus;
    logic          bus_strobe_o, c_strobe;
    logic [NA:0]   grant_o, c_grant;
    logic [5:0]    slot_o, c_slot;
    logic [1:0]    cycle_o, c_cycle;
    logic          frame_end_o, c_end;
    logic          conflict_o, c_conflict;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tdm_slot_sequencer dut (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .tick_i(tick_i),
        .rtr_valid_i(rtr_valid_i), .rtr_data_i(rtr_data_i),
        .dsp_valid_i(dsp_valid_i), .dsp_data_i(dsp_data_i),
        .bus_data_o(bus_data_o), .bus_strobe_o(bus_strobe_o), .grant_o(grant_o),
        .slot_o(slot_o), .cycle_o(cycle_o), .frame_end_o(frame_end_o),
        .conflict_o(conflict_o)
    );

    // agents 0 and 1 both on slot 12, agent 2 on slot 40
    tdm_slot_sequencer #(.AGENT_SLOTS({6'd40, 6'd12, 6'd12})) dut_c (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .tick_i(tick_i),
        .rtr_valid_i(rtr_valid_i), .rtr_data_i(rtr_data_i),
        .dsp_valid_i(dsp_valid_i), .dsp_data_i(dsp_data_i),
        .bus_data_o(c_bus), .bus_strobe_o(c_strobe), .grant_o(c_grant),
        .slot_o(c_slot), .cycle_o(c_cycle), .frame_end_o(c_end),
        .conflict_o(c_conflict)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_dsp(input int i, input logic v, input logic [DW-1:0] d);
        dsp_valid_i[i] = v;
        dsp_data_i[i*DW +: DW] = d;
    endtask

    task automatic idle_inputs();
        frame_start_i = 0; tick_i = 0; rtr_valid_i = 0; rtr_data_i = '0;
        dsp_valid_i = '0; dsp_data_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle_inputs();
        tick_i = 1; rtr_valid_i = 1; rtr_data_i = 24'h5A5A5A; dsp_valid_i = '1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // open a frame and consume slot*4+cyc bus cycles; returns at a negedge
    task automatic go_to(input int slot, input int cyc);
        frame_start_i = 1; tick_i = 0;
        @(negedge clk);
        frame_start_i = 0;
        for (int n = 0; n < slot * 4 + cyc; n++) begin
            tick_i = 1;
            @(negedge clk);
        end
        tick_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1", "slot", 32'(slot_o), 0);
        check("R1", "cycle", 32'(cycle_o), 0);
        check("R1", "grant", 32'(grant_o), 0);
        check("R1", "bus", 32'(bus_data_o), 0);
        check("R1", "strobe", 32'(bus_strobe_o), 0);
        check("R1", "frame_end", 32'(frame_end_o), 0);
        check("R1", "conflict", 32'(conflict_o), 0);
        repeat (4) @(negedge clk);
        #1;
        check("R1", "slot after ticks without frame", 32'(slot_o), 0);
        check("R1", "cycle after ticks without frame", 32'(cycle_o), 0);
        idle_inputs();
    endtask

    task automatic t_count();
        idle_inputs();
        @(negedge clk);
        go_to(1, 1);
        #1;
        check("R3", "slot after 5 ticks", 32'(slot_o), 1);
        check("R3", "cycle after 5 ticks", 32'(cycle_o), 1);
        repeat (3) @(negedge clk);
        #1;
        check("R3", "slot held without tick", 32'(slot_o), 1);
        check("R3", "cycle held without tick", 32'(cycle_o), 1);
        frame_start_i = 1; tick_i = 1;
        @(negedge clk);
        frame_start_i = 0; tick_i = 0;
        #1;
        check("R2", "slot after start+tick", 32'(slot_o), 0);
        check("R2", "cycle after start+tick", 32'(cycle_o), 0);
        check("R2", "router granted at slot 0", 32'(grant_o), 32'b1000);
    endtask

    task automatic t_router();
        idle_inputs();
        @(negedge clk);
        go_to(3, 1);
        dsp_valid_i = '1;
        set_dsp(0, 1, 24'h111111); set_dsp(1, 1, 24'h222222); set_dsp(2, 1, 24'h333333);
        rtr_valid_i = 1; rtr_data_i = 24'h123456;
        #1;
        check("R5", "router grant", 32'(grant_o), 32'b1000);
        check("R5", "router word on bus", 32'(bus_data_o), 32'h123456);
        check("R8", "no strobe without tick", 32'(bus_strobe_o), 0);
        tick_i = 1;
        #1;
        check("R8", "strobe with tick", 32'(bus_strobe_o), 1);
        @(negedge clk);
        tick_i = 0; rtr_valid_i = 0;
        #1;
        check("R7", "router not valid gives zero bus", 32'(bus_data_o), 0);
        check("R7", "router not valid no strobe", 32'(bus_strobe_o), 0);
        idle_inputs();
    endtask

    task automatic t_dsp();
        idle_inputs();
        @(negedge clk);
        go_to(20, 0);
        for (int k = 0; k < 4; k++) begin
            set_dsp(0, 1, 24'hA00000 + 24'(k));
            set_dsp(1, (k != 2), 24'hB00000 + 24'(k));
            set_dsp(2, 1, 24'hC00000 + 24'(k));
            rtr_valid_i = 1; rtr_data_i = 24'hDEAD00;
            tick_i = 1;
            #1;
            check("R6", "agent1 grant", 32'(grant_o), 32'b0010);
            if (k != 2) begin
                check("R6", "agent1 word", 32'(bus_data_o), 32'hB00000 + 32'(k));
                check("R8", "agent1 strobe", 32'(bus_strobe_o), 1);
            end else begin
                check("R7", "agent1 invalid word zero", 32'(bus_data_o), 0);
                check("R7", "agent1 invalid no strobe", 32'(bus_strobe_o), 0);
            end
            @(negedge clk);
        end
        tick_i = 0;
        #1;
        check("R7", "unowned slot 21 grant", 32'(grant_o), 0);
        check("R7", "unowned slot 21 bus", 32'(bus_data_o), 0);
        check("R3", "slot after 4 words", 32'(slot_o), 21);
        idle_inputs();
    endtask

    task automatic t_end();
        idle_inputs();
        @(negedge clk);
        go_to(63, 2);
        set_dsp(2, 1, 24'h630002);
        tick_i = 1;
        #1;
        check("R4", "no frame_end at 63/2", 32'(frame_end_o), 0);
        check("R6", "agent2 word 63/2", 32'(bus_data_o), 32'h630002);
        @(negedge clk);
        set_dsp(2, 1, 24'h630003);
        #1;
        check("R4", "frame_end at 63/3", 32'(frame_end_o), 1);
        check("R6", "agent2 word 63/3", 32'(bus_data_o), 32'h630003);
        @(negedge clk);
        #1;
        check("R4", "slot held after close", 32'(slot_o), 63);
        check("R4", "cycle held after close", 32'(cycle_o), 3);
        check("R4", "no frame_end after close", 32'(frame_end_o), 0);
        check("R4", "no grant after close", 32'(grant_o), 0);
        check("R7", "bus zero after close", 32'(bus_data_o), 0);
        check("R8", "no strobe after close", 32'(bus_strobe_o), 0);
        tick_i = 0; frame_start_i = 1;
        @(negedge clk);
        frame_start_i = 0;
        #1;
        check("R2", "reopen slot", 32'(slot_o), 0);
        check("R2", "reopen grant router", 32'(grant_o), 32'b1000);
        idle_inputs();
    endtask

    task automatic t_conflict();
        do_reset();
        idle_inputs();
        @(negedge clk);
        go_to(11, 3);
        #1;
        check("R9", "no conflict before shared slot", 32'(c_conflict), 0);
        tick_i = 1;
        @(negedge clk);
        tick_i = 0;
        set_dsp(0, 0, 24'h0A0A0A); set_dsp(1, 1, 24'h0B0B0B);
        #1;
        check("R9", "lower agent granted", 32'(c_grant), 32'b0001);
        check("R9", "higher agent word ignored", 32'(c_bus), 0);
        check("R9", "flag not yet set", 32'(c_conflict), 0);
        set_dsp(0, 1, 24'h0A0A0A);
        #1;
        check("R9", "lower agent word on bus", 32'(c_bus), 32'h0A0A0A);
        @(negedge clk);
        #1;
        check("R9", "conflict raised", 32'(c_conflict), 1);
        frame_start_i = 1;
        @(negedge clk);
        frame_start_i = 0;
        @(negedge clk);
        #1;
        check("R9", "conflict sticky across frame start", 32'(c_conflict), 1);
        check("R9", "no conflict on distinct slots", 32'(conflict_o), 0);
        idle_inputs();
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_count();
        t_router();
        t_dsp();
        t_end();
        t_conflict();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule